// File: doc/BRIEF.md
# Shared-Period Input Debounce Filter

This block cleans up a bank of slow, already-synchronized digital inputs. Three period registers hold debounce lengths in clock cycles, and every pin is tied to one of them or to no filtering at all. Software chooses which pins share a length by setting the pin's two select bits, and it writes the period values over a small register port. The block does not decide which period a pin gets.

For each filtered pin, a counter measures how long the raw level has differed from the filtered level. The filtered level changes only when the difference has lasted for the whole selected period. A pin with select index 0, or one bound to a register that holds 0, passes its raw input straight through in the same cycle. The register port is a plain single-cycle write strobe with a combinational read. The pin vectors are level signals sampled on every clock, so there is no valid/ready handshake and no back-pressure anywhere. A write is accepted on the edge where `reg_wr` is high. A read returns the addressed register in the same cycle.

Top module: `dbnc_shared_top`

## Requirements
- R1: While `rst_n` is low, `pin_flt` is all zeros whatever `pin_raw` is. After reset, all three period registers read back 0.
- R2: Word offsets 0x00, 0x04 and 0x08 (`reg_addr[3:2]` = 0, 1, 2, low two bits zero) select period registers 0, 1 and 2. A write on an edge with `reg_wr` high stores `reg_wdata`, and `reg_rdata` shows the addressed register in the same cycle. For offset 0x0C or any unaligned address, a write changes nothing and the read gives 0.
- R3: A pin's select index is {`pin_sel_hi[i]`, `pin_sel_lo[i]`}, with the hi bit as the MSB. With index 0, `pin_flt[i]` equals `pin_raw[i]` in the same cycle.
- R4: Index 1 uses period register 0, index 2 uses register 1, and index 3 uses register 2.
- R5: With a nonzero index and a selected period P > 0, `pin_flt[i]` takes the raw level at the P-th consecutive rising edge at which the raw input differs from the filtered output. Before that edge, the output keeps its old level.
- R6: If the raw input returns to the filtered level before P consecutive differing edges have occurred, the output does not change. The count starts again from zero at the next difference.
- R7: A selected period of 0 acts as bypass: the output equals the raw input in the same cycle.
- R8: Pins that select the same register share its value. A rewrite of a register changes the period of every pin bound to it.
- R9: When a pin's index changes from one nonzero value to another, its count restarts on that edge and its output level is kept. The differing-edge count of R5 begins at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| pin_sel_hi | input | 8 | Per-pin high select bit |
| pin_sel_lo | input | 8 | Per-pin low select bit |
| pin_raw | input | 8 | Synchronized raw pin levels |
| pin_flt | output | 8 | Filtered pin levels |

## Verification
The assertions check four things on every cycle:
- a write to a mapped offset lands in the addressed register;
- an unmapped write leaves all registers unchanged;
- a filtered pin whose raw level matches its output holds that output;
- a nonzero counter always follows a cycle of raw/output difference, and a change between nonzero selects clears the count while keeping the level.

Only the bench scenarios can show the rest. These are the exact edge at which the output flips for each period and register, the same-cycle pass-through in bypass and zero-period modes, glitch rejection, and one register rewrite retiming several pins at once.

// File: rtl/dbnc_pkg.sv
`timescale 1ns/1ps
package dbnc_pkg;
  localparam int unsigned DB_NUM_TIMERS = 3;
  localparam int unsigned DB_SEL_W      = 2;

  typedef enum logic [DB_SEL_W-1:0] {
    DB_SEL_OFF = 2'd0,
    DB_SEL_T0  = 2'd1,
    DB_SEL_T1  = 2'd2,
    DB_SEL_T2  = 2'd3
  } db_sel_e;
endpackage

// File: rtl/dbnc_period_file.sv
`timescale 1ns/1ps
module dbnc_period_file #(
  parameter int unsigned AW = 4,
  parameter int unsigned PW = 32,
  parameter int unsigned NT = dbnc_pkg::DB_NUM_TIMERS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [PW-1:0]          wdata_i,
  output logic [PW-1:0]          rdata_o,
  output logic [NT-1:0][PW-1:0]  per_o
);
  localparam int unsigned WIDX_W = AW - 2;

  logic [WIDX_W-1:0] widx;
  logic              hit;

  assign widx = addr_i[AW-1:2];
  assign hit  = (addr_i[1:0] == 2'b00) && (int'(widx) < int'(NT));

  for (genvar t = 0; t < NT; t++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        per_o[t] <= '0;
      else if (wr_i && hit && (int'(widx) == t))
        per_o[t] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int t = 0; t < int'(NT); t++)
      if (hit && (int'(widx) == t))
        rdata_o = per_o[t];
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit) |=> per_o[$past(widx)] == $past(wdata_i));

  // R2
  wr_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !hit) |=> $stable(per_o));
endmodule

// File: rtl/dbnc_lane.sv
`timescale 1ns/1ps
module dbnc_lane #(
  parameter int unsigned PW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          raw_i,
  input  logic [dbnc_pkg::DB_SEL_W-1:0] sel_i,
  input  logic [PW-1:0]                 period_i,
  output logic                          flt_o
);
  import dbnc_pkg::*;

  logic                out_q;
  logic [PW-1:0]       cnt_q;
  logic [DB_SEL_W-1:0] sel_q;
  logic [PW:0]         cnt_nxt;
  logic                byp;
  logic                sel_chg;
  logic                diff;

  assign byp     = (sel_i == DB_SEL_OFF) || (period_i == '0);
  assign sel_chg = (sel_i != sel_q);
  assign diff    = (raw_i != out_q);
  assign cnt_nxt = {1'b0, cnt_q} + (PW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
      sel_q <= DB_SEL_OFF;
    end else begin
      sel_q <= sel_i;
      if (byp) begin
        out_q <= raw_i;
        cnt_q <= '0;
      end else if (sel_chg || !diff) begin
        cnt_q <= '0;
      end else if (cnt_nxt >= {1'b0, period_i}) begin
        out_q <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt[PW-1:0];
      end
    end
  end

  assign flt_o = (rst_n && byp) ? raw_i : out_q;

  // R6
  hold_when_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && !diff) |=> $stable(out_q));

  // R5
  cnt_follows_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(raw_i != out_q));

  // R9
  sel_change_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && sel_chg) |=> (cnt_q == '0 && $stable(out_q)));
endmodule

// File: rtl/dbnc_shared_top.sv
`timescale 1ns/1ps
module dbnc_shared_top #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned AW     = 4,
  parameter int unsigned PW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [PW-1:0]     reg_wdata,
  output logic [PW-1:0]     reg_rdata,
  input  logic [N_PINS-1:0] pin_sel_hi,
  input  logic [N_PINS-1:0] pin_sel_lo,
  input  logic [N_PINS-1:0] pin_raw,
  output logic [N_PINS-1:0] pin_flt
);
  import dbnc_pkg::*;

  localparam int unsigned NT = DB_NUM_TIMERS;

  logic [NT-1:0][PW-1:0] per;

  dbnc_period_file #(.AW(AW), .PW(PW), .NT(NT)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .per_o   (per)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [DB_SEL_W-1:0] idx;
    logic [PW-1:0]       sel_per;

    assign idx = {pin_sel_hi[g], pin_sel_lo[g]};

    always_comb begin
      case (idx)
        DB_SEL_T0: sel_per = per[0];
        DB_SEL_T1: sel_per = per[1];
        DB_SEL_T2: sel_per = per[2];
        default:   sel_per = '0;
      endcase
    end

    dbnc_lane #(.PW(PW)) lane_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_i    (pin_raw[g]),
      .sel_i    (idx),
      .period_i (sel_per),
      .flt_o    (pin_flt[g])
    );
  end
endmodule

// File: tb/dbnc_shared_top_tb_top.sv
`timescale 1ns/1ps
module dbnc_shared_top_tb_top;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  pin_sel_hi = '0;
  logic [N-1:0]  pin_sel_lo = '0;
  logic [N-1:0]  pin_raw = '0;
  logic [N-1:0]  pin_flt;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dbnc_shared_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_sel_hi(pin_sel_hi),
    .pin_sel_lo(pin_sel_lo), .pin_raw(pin_raw), .pin_flt(pin_flt)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic set_idx(logic [1:0] s);
    pin_sel_hi = {N{s[1]}};
    pin_sel_lo = {N{s[0]}};
  endtask

  task automatic clear_out();
    set_idx(2'd0); pin_raw = '0;
    tick();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low
    pin_raw = '1;
    tick(); tick();
    chk("R1 flt in reset", 32'(pin_flt), 32'h0);
    rst_n = 1'b1;
    pin_raw = '0;
    tick();
    rd_chk("R1 reg0", 4'h0, 0);
    rd_chk("R1 reg1", 4'h4, 0);
    rd_chk("R1 reg2", 4'h8, 0);

    // R3: index 0 is a same-cycle pass-through
    for (int v = 0; v < 16; v++) begin
      pin_raw = N'(v * 37 + 5);
      #1 chk("R3 bypass", 32'(pin_flt), 32'(pin_raw));
      tick();
    end

    // R2: write/readback and unmapped addresses
    wr(4'h0, 32'hA5A5_0001);
    wr(4'h4, 32'h5A5A_0002);
    wr(4'h8, 32'hDEAD_0003);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h1, 32'h1234_5678);
    rd_chk("R2 reg0", 4'h0, 32'hA5A5_0001);
    rd_chk("R2 reg1", 4'h4, 32'h5A5A_0002);
    rd_chk("R2 reg2", 4'h8, 32'hDEAD_0003);
    rd_chk("R2 unmapped", 4'hC, 0);
    rd_chk("R2 unaligned", 4'h5, 0);

    // R4 R5: sweep registers and periods
    for (int r = 0; r < 3; r++) begin
      for (int p = 1; p <= 4; p++) begin
        clear_out();
        for (int t = 0; t < 3; t++) wr(4'(t * 4), (t == r) ? 32'(p) : 32'd6);
        set_idx(2'(r + 1));
        tick();
        pin_raw = '1;
        #1 chk("R5 before edge", 32'(pin_flt), 0);
        for (int n = 1; n <= p + 1; n++) begin
          tick();
          chk("R4 R5 rise", 32'(pin_flt), (n >= p) ? 32'hFF : 32'h0);
        end
      end
    end

    // R6: short glitch is rejected
    clear_out();
    wr(4'h0, 4); wr(4'h4, 6); wr(4'h8, 6);
    set_idx(2'd1);
    tick();
    pin_raw = '1; tick(); tick();
    pin_raw = '0; tick();
    chk("R6 glitch", 32'(pin_flt), 0);
    pin_raw = '1;
    for (int n = 1; n <= 4; n++) begin
      tick();
      chk("R6 recount", 32'(pin_flt), (n >= 4) ? 32'hFF : 32'h0);
    end

    // R7: zero period acts as bypass
    clear_out();
    wr(4'h4, 0);
    set_idx(2'd2);
    for (int v = 0; v < 8; v++) begin
      pin_raw = N'(v * 53 + 9);
      #1 chk("R7 zero period", 32'(pin_flt), 32'(pin_raw));
      tick();
    end

    // R8: shared registers, rewrite retimes all bound pins
    clear_out();
    wr(4'h0, 3); wr(4'h4, 6); wr(4'h8, 5);
    pin_sel_hi = 8'hF0; pin_sel_lo = 8'hFF;
    tick();
    pin_raw = '1;
    for (int n = 1; n <= 5; n++) begin
      tick();
      chk("R8 shared", 32'(pin_flt),
          32'({(n >= 5) ? 4'hF : 4'h0, (n >= 3) ? 4'hF : 4'h0}));
    end
    wr(4'h0, 1); wr(4'h8, 2);
    pin_raw = '0;
    tick();
    chk("R8 rewrite 1", 32'(pin_flt), 32'hF0);
    tick();
    chk("R8 rewrite 2", 32'(pin_flt), 32'h00);

    // R9: select change restarts the count and keeps the level
    wr(4'h0, 3); wr(4'h4, 3);
    set_idx(2'd1);
    tick();
    pin_raw = '1; tick(); tick();
    set_idx(2'd2);
    tick();
    chk("R9 hold low", 32'(pin_flt), 0);
    for (int n = 1; n <= 3; n++) begin
      tick();
      chk("R9 recount", 32'(pin_flt), (n >= 3) ? 32'hFF : 32'h0);
    end
    pin_raw = '0; tick();
    set_idx(2'd3);
    tick();
    chk("R9 hold high", 32'(pin_flt), 32'hFF);
    tick();
    chk("R9 count 1", 32'(pin_flt), 32'hFF);
    tick();
    chk("R9 count 2", 32'(pin_flt), 32'h00);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule